// File: doc/BRIEF.md
# SPI Flash Command Access Guard

This block sits between a byte-wide register bus and an SPI serial shift engine. It decides whether software may run a flash command. Software loads a flash address and a command byte. The guard judges the command byte in the cycle it is written and records the verdict in a sticky illegal-access flag. When software then sets the execute bit, the command goes to the shift engine only if that flag is clear. Bytes that the engine returns are collected in a small read window that software can read back.

Two enable bits in the control register shape the verdict. When either of them is 0, the block applies a list of eight restricted opcodes. When the lower enable is 1, the block also guards a protected low-address window against the two flash read opcodes. Software can only lower either enable. Only a reset raises it again.

The bus map is as follows. The command byte is at 0x00. Control byte 0x02 holds bits 16 to 23 of the control word. Restricted opcode slots 0 to 7 are at 0x04 to 0x0B. The flash address is at 0x0C to 0x0E, low byte first. The receive window is at 0x80 to 0x87.

Top module: `spi_cmd_guard`

## Requirements
- R1: After reset, 0x00 reads 0x00, 0x02 reads 0xC0 (both enables 1, execute 0, illegal 0), every restricted slot reads 0x00 and the window at 0x80 reads 0x00.
- R2: When either enable is 0, writing 0x00 with an opcode equal to a non-zero restricted slot sets the illegal flag (bit 1 of byte 0x02) straight away, with no execute request.
- R3: Writing a command byte that is neither restricted nor in the protected window clears the illegal flag.
- R4: While both enables are 1, the restricted slots are not applied. A slot holding 0x00 never matches, not even opcode 0x00.
- R5: Byte 0x02 bit 6 (control bit 22) and bit 7 (control bit 23) are cleared by writing 0. Writing 1 to them never sets them again before reset.
- R6: While bit 6 of 0x02 is 1, opcodes 0x03 and 0x0B written while the flash address is below 0x80000 set the illegal flag. At 0x80000 or above, or with bit 6 at 0, they are legal.
- R7: Writing 1 to bit 0 of 0x02 while the illegal flag is set starts nothing and leaves the window contents and the execute bit unchanged.
- R8: Writing 1 to bit 0 of 0x02 with the flag clear pulses eng_start for exactly one cycle in the next cycle, carrying the stored opcode and address. Bit 0 reads 1 until the cycle after eng_done.
- R9: Returned bytes fill 0x80 upward in arrival order. At most 8 bytes are kept. Reads past the stored count return 0x00. Starting a command empties the window.
- R10: While a command is in progress, writes to 0x00, 0x02 and the flash address bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read enable; read data is combinational |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when bus_rd is low |
| eng_start | output | 1 | One-cycle start pulse to the shift engine |
| eng_opcode | output | 8 | Command byte for the engine |
| eng_addr | output | 24 | Flash address for the engine |
| eng_rx_valid | input | 1 | Engine returns a byte this cycle |
| eng_rx_data | input | 8 | Returned byte |
| eng_done | input | 1 | Engine transaction finished |

## Verification
Register reads are combinational. A write taken at one clock edge can therefore be read back through the bus, including the illegal-flag verdict, half a cycle later at the next falling edge. The bench drives on falling edges and samples just after them. eng_start rises one cycle after the accepted execute write, and the engine model in the bench picks it up at the first falling edge after that. The model then checks the pulse against the queued expected opcode and address. Window contents are read only after the execute bit has been polled back to 0, which happens one cycle after eng_done.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;
   localparam logic [7:0] OFS_CMD   = 8'h00;
   localparam logic [7:0] OFS_CTL   = 8'h02;
   localparam logic [7:0] OFS_RSTR  = 8'h04;
   localparam logic [7:0] OFS_FADR  = 8'h0C;
   localparam logic [7:0] OFS_WIN   = 8'h80;
   localparam logic [7:0] OP_READ   = 8'h03;
   localparam logic [7:0] OP_FREAD  = 8'h0B;

   typedef struct packed {
      logic       host_en;
      logic       mac_en;
      logic [3:0] rsvd;
      logic       illegal;
      logic       busy;
   } ctl_byte_t;

   function automatic logic [7:0] ofs(logic [7:0] base, int k);
      return base + 8'(k);
   endfunction
endpackage

// File: rtl/spi_guard_filter.sv
module spi_guard_filter
   import spi_guard_pkg::*;
#(
   parameter int N_SLOTS = 8,
   parameter int FADDR_W = 24,
   parameter logic [FADDR_W-1:0] PROT_LIMIT = 'h80000
) (
   input  logic [7:0]           opcode,
   input  logic [N_SLOTS*8-1:0] slots,
   input  logic                 mac_en,
   input  logic                 host_en,
   input  logic [FADDR_W-1:0]   faddr,
   output logic                 blocked
);
   logic [N_SLOTS-1:0] hit;
   logic enforce, is_read, in_low;

   for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      assign hit[i] = (slots[i*8 +: 8] != 8'h00) && (slots[i*8 +: 8] == opcode);
   end

   assign enforce = !(mac_en && host_en);
   assign is_read = (opcode == OP_READ) || (opcode == OP_FREAD);
   assign in_low  = faddr < PROT_LIMIT;
   assign blocked = (enforce && |hit) || (mac_en && is_read && in_low);
endmodule

// File: rtl/spi_guard_rxbuf.sv
module spi_guard_rxbuf #(
   parameter int DEPTH = 8,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [7:0]    din,
   input  logic [7:0]    idx,
   output logic [7:0]    dout,
   output logic [CW-1:0] fill
);
   logic [7:0]    mem [DEPTH];
   logic [CW-1:0] cnt;

   if (DEPTH < 1 || DEPTH > 128) begin : g_bad_depth
      $error("spi_guard_rxbuf: DEPTH must be 1..128");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (push && (int'(cnt) < DEPTH)) begin
         mem[cnt[IW-1:0]] <= din;
         cnt <= cnt + 1'b1;
      end
   end

   assign dout = (int'(idx) < int'(cnt)) ? mem[idx[IW-1:0]] : 8'h00;
   assign fill = cnt;
endmodule

// File: rtl/spi_cmd_guard.sv
module spi_cmd_guard
   import spi_guard_pkg::*;
#(
   parameter int          FADDR_W    = 24,
   parameter int          RSTR_REGS  = 2,
   parameter int          SLOTS_PER  = 4,
   parameter int          FIFO_DEPTH = 8,
   parameter int unsigned PROT_LIMIT = 32'h0008_0000,
   localparam int N_SLOTS = RSTR_REGS * SLOTS_PER,
   localparam int FB      = FADDR_W / 8,
   localparam int CW      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic               eng_start,
   output logic [7:0]         eng_opcode,
   output logic [FADDR_W-1:0] eng_addr,
   input  logic               eng_rx_valid,
   input  logic [7:0]         eng_rx_data,
   input  logic               eng_done
);
   if (FADDR_W % 8 != 0 || FB < 1 || FB > 4) begin : g_bad_faddr
      $error("spi_cmd_guard: FADDR_W must be 8, 16, 24 or 32");
   end
   if (RSTR_REGS < 1 || RSTR_REGS > 2 || SLOTS_PER != 4) begin : g_bad_rstr
      $error("spi_cmd_guard: restricted registers must fit 0x04..0x0B");
   end
   if (FIFO_DEPTH > 128) begin : g_bad_fifo
      $error("spi_cmd_guard: FIFO_DEPTH exceeds window");
   end

   logic [7:0]           cmd_q;
   logic                 ill_q, busy_q, start_q, mac_q, host_q;
   logic [FADDR_W-1:0]   faddr_q;
   logic [N_SLOTS*8-1:0] slots_q;
   logic                 blocked, wr_ok, exec_go;
   logic [7:0]           win_data, rd_val;
   logic [CW-1:0]        rx_fill;
   ctl_byte_t            cv;

   spi_guard_filter #(
      .N_SLOTS(N_SLOTS), .FADDR_W(FADDR_W), .PROT_LIMIT(FADDR_W'(PROT_LIMIT))
   ) u_filter (
      .opcode(bus_wdata), .slots(slots_q), .mac_en(mac_q), .host_en(host_q),
      .faddr(faddr_q), .blocked(blocked)
   );

   assign wr_ok   = bus_wr && !busy_q;
   assign exec_go = wr_ok && (bus_addr == OFS_CTL) && bus_wdata[0] && !ill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         ill_q   <= 1'b0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         mac_q   <= 1'b1;
         host_q  <= 1'b1;
         faddr_q <= '0;
         slots_q <= '0;
      end else begin
         start_q <= 1'b0;
         if (busy_q && eng_done) busy_q <= 1'b0;
         if (wr_ok && bus_addr == OFS_CMD) begin
            cmd_q <= bus_wdata;
            ill_q <= blocked;
         end
         if (wr_ok && bus_addr == OFS_CTL) begin
            mac_q  <= mac_q  & bus_wdata[6];
            host_q <= host_q & bus_wdata[7];
         end
         if (exec_go) begin
            busy_q  <= 1'b1;
            start_q <= 1'b1;
         end
         for (int b = 0; b < FB; b++) begin
            if (wr_ok && bus_addr == ofs(OFS_FADR, b)) faddr_q[b*8 +: 8] <= bus_wdata;
         end
         for (int s = 0; s < N_SLOTS; s++) begin
            if (bus_wr && bus_addr == ofs(OFS_RSTR, s)) slots_q[s*8 +: 8] <= bus_wdata;
         end
      end
   end

   spi_guard_rxbuf #(.DEPTH(FIFO_DEPTH)) u_rxbuf (
      .clk(clk), .rst_n(rst_n), .clr(exec_go), .push(busy_q && eng_rx_valid),
      .din(eng_rx_data), .idx(bus_addr - OFS_WIN), .dout(win_data), .fill(rx_fill)
   );

   always_comb begin
      cv = '{host_en: host_q, mac_en: mac_q, rsvd: 4'b0, illegal: ill_q, busy: busy_q};
      rd_val = 8'h00;
      if (bus_addr == OFS_CMD) rd_val = cmd_q;
      if (bus_addr == OFS_CTL) rd_val = cv;
      for (int s = 0; s < N_SLOTS; s++) begin
         if (bus_addr == ofs(OFS_RSTR, s)) rd_val = slots_q[s*8 +: 8];
      end
      for (int b = 0; b < FB; b++) begin
         if (bus_addr == ofs(OFS_FADR, b)) rd_val = faddr_q[b*8 +: 8];
      end
      if (bus_addr >= OFS_WIN) rd_val = win_data;
   end

   assign bus_rdata  = bus_rd ? rd_val : 8'h00;
   assign eng_start  = start_q;
   assign eng_opcode = cmd_q;
   assign eng_addr   = faddr_q;
endmodule

// File: rtl/spi_guard_chk.sv
module spi_guard_chk #(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    bus_addr,
   input logic          bus_wr,
   input logic [7:0]    bus_wdata,
   input logic          eng_start,
   input logic          eng_done,
   input logic [7:0]    cmd_q,
   input logic          ill_q,
   input logic          busy_q,
   input logic          mac_q,
   input logic          host_q,
   input logic [CW-1:0] rx_fill
);
   p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> busy_q && !eng_done || busy_q);
   p_exec_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h02 && bus_wdata[0] && ill_q) |=> !eng_start);
   p_mac_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mac_q |=> !mac_q);
   p_host_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !host_q |=> !host_q);
   p_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !busy_q && bus_addr == 8'h00 && mac_q && host_q
       && bus_wdata != 8'h03 && bus_wdata != 8'h0B) |=> !ill_q);
   p_ctl_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(cmd_q));
   p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fill <= CW'(DEPTH));
   p_start_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> rx_fill == '0);
endmodule

bind spi_cmd_guard spi_guard_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .eng_start(eng_start), .eng_done(eng_done),
   .cmd_q(cmd_q), .ill_q(ill_q), .busy_q(busy_q), .mac_q(mac_q),
   .host_q(host_q), .rx_fill(rx_fill)
);

// File: tb/spi_cmd_guard_test.sv
`timescale 1ns/1ps
module spi_cmd_guard_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0, bus_wdata = '0, bus_rdata;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic        eng_start, eng_rx_valid, eng_done;
   logic [7:0]  eng_opcode, eng_rx_data;
   logic [23:0] eng_addr;

   int checks = 0;
   int errors = 0;
   int eng_nbytes = 0;

   typedef struct {logic [7:0] op; logic [23:0] ad;} job_t;
   job_t exp_q[$];

   always #2.5 clk = ~clk;

   spi_cmd_guard uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_start(eng_start), .eng_opcode(eng_opcode), .eng_addr(eng_addr),
      .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data), .eng_done(eng_done)
   );

   function automatic logic [7:0] dat(logic [7:0] op, int i);
      return op + 8'(i * 17);
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr_reg(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
      logic [7:0] v;
      peek(a, v);
      chk(tag, {24'b0, v}, {24'b0, exp});
   endtask

   task automatic wait_idle();
      logic [7:0] v;
      for (int n = 0; n < 200; n++) begin
         peek(8'h02, v);
         if (!v[0]) break;
      end
   endtask

   task automatic set_faddr(logic [23:0] a);
      wr_reg(8'h0C, a[7:0]);
      wr_reg(8'h0D, a[15:8]);
      wr_reg(8'h0E, a[23:16]);
   endtask

   // Scoreboard monitor and shift-engine model
   initial begin
      job_t j;
      logic [7:0] op;
      eng_rx_valid = 1'b0; eng_done = 1'b0; eng_rx_data = '0;
      forever begin
         @(negedge clk);
         if (eng_start) begin
            op = eng_opcode;
            if (exp_q.size() == 0) begin
               chk("R7 unexpected start", {24'b0, op}, 32'h0);
            end else begin
               j = exp_q.pop_front();
               chk("R8 opcode", {24'b0, op}, {24'b0, j.op});
               chk("R8 address", {8'b0, eng_addr}, {8'b0, j.ad});
            end
            repeat (6) @(negedge clk);
            for (int i = 0; i < eng_nbytes; i++) begin
               eng_rx_valid = 1'b1; eng_rx_data = dat(op, i);
               @(negedge clk);
            end
            eng_rx_valid = 1'b0; eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk("R1 cmd", 8'h00, 8'h00);
      rd_chk("R1 ctl", 8'h02, 8'hC0);
      rd_chk("R1 slot", 8'h04, 8'h00);
      rd_chk("R1 window", 8'h80, 8'h00);

      // R3/R8/R9/R10 allowed command runs
      wr_reg(8'h00, 8'h9F);
      rd_chk("R3 legal cmd", 8'h02, 8'hC0);
      exp_q.push_back('{op: 8'h9F, ad: 24'h0});
      eng_nbytes = 3;
      wr_reg(8'h02, 8'hC1);
      rd_chk("R8 busy", 8'h02, 8'hC1);
      wr_reg(8'h00, 8'h05);
      rd_chk("R10 cmd frozen", 8'h00, 8'h9F);
      wait_idle();
      rd_chk("R8 idle", 8'h02, 8'hC0);
      rd_chk("R9 byte0", 8'h80, dat(8'h9F, 0));
      rd_chk("R9 byte1", 8'h81, dat(8'h9F, 1));
      rd_chk("R9 byte2", 8'h82, dat(8'h9F, 2));
      rd_chk("R9 past count", 8'h83, 8'h00);

      // R4 restrictions off while both enables set
      wr_reg(8'h04, 8'h9F);
      wr_reg(8'h00, 8'h9F);
      rd_chk("R4 unlocked", 8'h02, 8'hC0);
      // R5 clear-once
      wr_reg(8'h02, 8'h40);
      rd_chk("R5 cleared", 8'h02, 8'h40);
      wr_reg(8'h02, 8'hC0);
      rd_chk("R5 not reset", 8'h02, 8'h40);
      // R2 restricted opcode flagged at write
      wr_reg(8'h00, 8'h9F);
      rd_chk("R2 flagged", 8'h02, 8'h42);
      // R7 execute blocked
      wr_reg(8'h02, 8'h41);
      repeat (10) @(negedge clk);
      rd_chk("R7 no exec", 8'h02, 8'h42);
      rd_chk("R7 window kept", 8'h80, dat(8'h9F, 0));
      rd_chk("R7 window kept2", 8'h82, dat(8'h9F, 2));
      // R3 clears flag, R4 zero slot matches nothing
      wr_reg(8'h00, 8'h05);
      rd_chk("R3 cleared", 8'h02, 8'h40);
      wr_reg(8'h00, 8'h00);
      rd_chk("R4 empty slot", 8'h02, 8'h40);

      // R6 protected low window
      set_faddr(24'h07FFFF);
      wr_reg(8'h00, 8'h03);
      rd_chk("R6 low read", 8'h02, 8'h42);
      set_faddr(24'h080000);
      wr_reg(8'h00, 8'h0B);
      rd_chk("R6 boundary ok", 8'h02, 8'h40);
      exp_q.push_back('{op: 8'h0B, ad: 24'h080000});
      eng_nbytes = 10;
      wr_reg(8'h02, 8'h41);
      wait_idle();
      rd_chk("R9 first", 8'h80, dat(8'h0B, 0));
      rd_chk("R9 last kept", 8'h87, dat(8'h0B, 7));
      rd_chk("R9 overflow", 8'h88, 8'h00);

      // R6 window off once bit 6 cleared; R2 list still applied
      wr_reg(8'h02, 8'h00);
      rd_chk("R5 both cleared", 8'h02, 8'h00);
      set_faddr(24'h000010);
      wr_reg(8'h00, 8'h9F);
      rd_chk("R2 still restricted", 8'h02, 8'h02);
      wr_reg(8'h00, 8'h03);
      rd_chk("R6 low allowed", 8'h02, 8'h00);
      exp_q.push_back('{op: 8'h03, ad: 24'h000010});
      eng_nbytes = 1;
      wr_reg(8'h02, 8'h01);
      wait_idle();
      rd_chk("R9 new cmd", 8'h80, dat(8'h03, 0));
      rd_chk("R9 cleared at start", 8'h81, 8'h00);
      chk("R8 all starts seen", exp_q.size(), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule